// File: doc/BRIEF.md
# Flash Burst Configuration Command Decoder

This block watches the write side of a flash device's host bus and looks for a three-write command sequence. The sequence loads the burst configuration. The host strobes an address in with an active-low address-valid line and strobes data in with an active-low write-enable line. The block detects the rising edge of each strobe on its own clock.

The first two writes form an unlock pair. The third write carries the command byte C0h. The new settings do not travel in the data word. They are taken from the address latched for that third write: the burst mode and the initial-access wait-state code. Any write that does not fit the expected step ends the sequence and puts the block back in array-read mode. A wait-state code outside the supported range also ends it.

The outputs are:
- the current wait-state code and the matching initial-access clock count;
- the burst mode;
- a flag that is high while the block is in array-read mode;
- a one-clock pulse each time the configuration changes.

Top module: `flash_cfg_decoder`

## Requirements
- R1: After reset, the wait-state code is 5, the access clock count is 7, the burst mode is 00 (continuous), the read-array flag is 1 and the done pulse is 0.
- R2: The address is latched only on a rising edge of `addrValidN`. A command write is evaluated only on a rising edge of `writeEnN`, using the address latched last. Changing `addrIn` without an address strobe has no effect on which address is used.
- R3: These three writes in order update the configuration: first address bits 11:0 = 555h with data AAh, then 2AAh with 55h, then 555h with C0h. The wait-state code is loaded from address bits 14:12 of the third write, and the burst mode from bits 16:15.
- R4: Burst mode values: 00 is continuous, 01 is 8-word linear wrap, 10 is 16-word linear wrap, 11 is 32-word linear wrap. The field is stored exactly as given by address bits 16:15.
- R5: `accessClocks` always equals the wait-state code plus 2, so codes 0 to 5 give 2 to 7 clocks.
- R6: A third write with wait-state code 6 or 7 loads nothing. The configuration stays unchanged, no done pulse occurs, and the block returns to array-read mode.
- R7: A wrong address or wrong data at any step ends the sequence and returns the block to array-read mode. The same applies to a correct write at the wrong step. The write that ends the sequence is not taken as a new first unlock write.
- R8: `readArray` is 0 from the accepted first unlock write until the sequence ends. At all other times it is 1.
- R9: `cfgDone` is high for exactly one clock, in the clock in which the new configuration first appears on the outputs. The configuration outputs never change without it.
- R10: Address bits 19:17 and data bits 15:8 are ignored in all three steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the strobes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset (hardware reset) |
| addrValidN | input | 1 | Active-low address strobe; the address is latched on its rising edge |
| writeEnN | input | 1 | Active-low write strobe; the write is evaluated on its rising edge |
| addrIn | input | 20 | Host address bus |
| dataIn | input | 16 | Host write data bus |
| waitCode | output | 3 | Current initial-access wait-state code |
| accessClocks | output | 4 | Initial access length in clocks (code + 2) |
| burstMode | output | 2 | Current burst mode |
| readArray | output | 1 | High when in array-read mode |
| cfgDone | output | 1 | One-clock pulse when the configuration is updated |

## Verification
The bench tries wait-state codes 6 and 7 on an otherwise valid sequence. A decoder that skipped the range check would load an unsupported latency.

It repeats a first unlock write in place of the second. A design that treated the aborting write as a fresh start would then accept the tail of the sequence.

It presents a new address without an address strobe. Logic that read the live bus instead of the latched address would wrongly match the unlock step.

Random runs set address bits 19:17 and data bits 15:8 and corrupt single cycles. These catch over-strict or over-loose compares, and a done pulse that lasts too long or fires on a reject.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

  // Command sequence progress
  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_GOT_AA   = 2'd1,
    SEQ_GOT_55   = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic seqActive;
  } ctrlStrobes_t;

  // Decoded bus events from datapath to control
  typedef struct packed {
    logic writeEvt;
    logic hitUnlockA;
    logic hitUnlockB;
    logic hitCommit;
  } busFlags_t;

endpackage

// File: rtl/flash_cfg_datapath.sv
module flash_cfg_datapath
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int MATCH_W       = 12,
  parameter int CMD_W         = 8,
  parameter int WAIT_W        = 3,
  parameter int BURST_W       = 2,
  parameter int WAIT_LSB      = 12,
  parameter int BURST_LSB     = 15,
  parameter int MAX_WAIT_CODE = 5,
  parameter int DEFAULT_WAIT  = 5,
  parameter int MIN_ACCESS    = 2,
  parameter logic [MATCH_W-1:0] ADDR_FIRST  = 12'h555,
  parameter logic [MATCH_W-1:0] ADDR_SECOND = 12'h2AA,
  parameter logic [MATCH_W-1:0] ADDR_THIRD  = 12'h555,
  parameter logic [CMD_W-1:0]   DATA_FIRST  = 8'hAA,
  parameter logic [CMD_W-1:0]   DATA_SECOND = 8'h55,
  parameter logic [CMD_W-1:0]   DATA_THIRD  = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrValidN,
  input  logic                 writeEnN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic [DATA_W-1:0]    dataIn,
  input  ctrlStrobes_t         strobes,
  output busFlags_t            flags,
  output logic [WAIT_W-1:0]    waitCode,
  output logic [WAIT_W:0]      accessClocks,
  output logic [BURST_W-1:0]   burstMode,
  output logic                 cfgDone
);

  localparam int ACC_W = WAIT_W + 1;

  logic                avdPrev;
  logic                wePrev;
  logic                avdRise;
  logic                weRise;
  logic [ADDR_W-1:0]   addrLatch;
  logic [MATCH_W-1:0]  addrLow;
  logic [CMD_W-1:0]    cmdByte;
  logic [WAIT_W-1:0]   codeField;
  logic [BURST_W-1:0]  burstField;
  logic                codeLegal;

  // Strobe edge detection on the block clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      avdPrev <= 1'b1;
      wePrev  <= 1'b1;
    end else begin
      avdPrev <= addrValidN;
      wePrev  <= writeEnN;
    end
  end

  assign avdRise = addrValidN & ~avdPrev;
  assign weRise  = writeEnN & ~wePrev;

  // Address holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
    end else if (avdRise) begin
      addrLatch <= addrIn;
    end
  end

  assign addrLow    = addrLatch[MATCH_W-1:0];
  assign cmdByte    = dataIn[CMD_W-1:0];
  assign codeField  = addrLatch[WAIT_LSB +: WAIT_W];
  assign burstField = addrLatch[BURST_LSB +: BURST_W];
  assign codeLegal  = (int'(codeField) <= MAX_WAIT_CODE);

  // Compare results handed to control
  always_comb begin
    flags.writeEvt   = weRise;
    flags.hitUnlockA = (addrLow == ADDR_FIRST)  && (cmdByte == DATA_FIRST);
    flags.hitUnlockB = (addrLow == ADDR_SECOND) && (cmdByte == DATA_SECOND);
    flags.hitCommit  = (addrLow == ADDR_THIRD)  && (cmdByte == DATA_THIRD) && codeLegal;
  end

  // Configuration register and update pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCode  <= WAIT_W'(DEFAULT_WAIT);
      burstMode <= '0;
      cfgDone   <= 1'b0;
    end else begin
      cfgDone <= strobes.loadCfg;
      if (strobes.loadCfg) begin
        waitCode  <= codeField;
        burstMode <= burstField;
      end
    end
  end

  assign accessClocks = ACC_W'(waitCode) + ACC_W'(MIN_ACCESS);

endmodule

// File: rtl/flash_cfg_ctrl.sv
module flash_cfg_ctrl
  import flash_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  busFlags_t    flags,
  output ctrlStrobes_t strobes
);

  seqState_t stateQ;
  seqState_t stateD;

  always_comb begin
    stateD = stateQ;
    if (flags.writeEvt) begin
      unique case (stateQ)
        SEQ_IDLE:   stateD = flags.hitUnlockA ? SEQ_GOT_AA : SEQ_IDLE;
        SEQ_GOT_AA: stateD = flags.hitUnlockB ? SEQ_GOT_55 : SEQ_IDLE;
        SEQ_GOT_55: stateD = SEQ_IDLE;
        default:    stateD = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    strobes.loadCfg   = flags.writeEvt && (stateQ == SEQ_GOT_55) && flags.hitCommit;
    strobes.seqActive = (stateQ != SEQ_IDLE);
  end

endmodule

// File: rtl/flash_cfg_decoder.sv
module flash_cfg_decoder
  import flash_cfg_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int WAIT_W        = 3,
  parameter int BURST_W       = 2,
  parameter int MAX_WAIT_CODE = 5,
  parameter int DEFAULT_WAIT  = 5,
  parameter int MIN_ACCESS    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrValidN,
  input  logic               writeEnN,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [WAIT_W-1:0]  waitCode,
  output logic [WAIT_W:0]    accessClocks,
  output logic [BURST_W-1:0] burstMode,
  output logic               readArray,
  output logic               cfgDone
);

  busFlags_t    flags;
  ctrlStrobes_t strobes;

  flash_cfg_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .WAIT_W        (WAIT_W),
    .BURST_W       (BURST_W),
    .MAX_WAIT_CODE (MAX_WAIT_CODE),
    .DEFAULT_WAIT  (DEFAULT_WAIT),
    .MIN_ACCESS    (MIN_ACCESS)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .addrValidN   (addrValidN),
    .writeEnN     (writeEnN),
    .addrIn       (addrIn),
    .dataIn       (dataIn),
    .strobes      (strobes),
    .flags        (flags),
    .waitCode     (waitCode),
    .accessClocks (accessClocks),
    .burstMode    (burstMode),
    .cfgDone      (cfgDone)
  );

  flash_cfg_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .flags   (flags),
    .strobes (strobes)
  );

  assign readArray = ~strobes.seqActive;

endmodule

// File: rtl/flash_cfg_decoder_chk.sv
module flash_cfg_decoder_chk #(
  parameter int WAIT_W        = 3,
  parameter int BURST_W       = 2,
  parameter int MAX_WAIT_CODE = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               writeEnN,
  input logic [WAIT_W-1:0]  waitCode,
  input logic [BURST_W-1:0] burstMode,
  input logic               readArray,
  input logic               cfgDone
);

  AST_DONE_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> !cfgDone); // R9

  AST_CFG_CHANGE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ((waitCode != $past(waitCode)) || (burstMode != $past(burstMode))) |-> cfgDone); // R9

  AST_WAIT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    int'(waitCode) <= MAX_WAIT_CODE); // R6

  AST_DONE_IN_READ_MODE: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> readArray); // R8

  AST_SEQ_START_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readArray) |-> ($past(writeEnN) && !$past(writeEnN, 2))); // R2

endmodule

bind flash_cfg_decoder flash_cfg_decoder_chk #(
  .WAIT_W        (WAIT_W),
  .BURST_W       (BURST_W),
  .MAX_WAIT_CODE (MAX_WAIT_CODE)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .writeEnN  (writeEnN),
  .waitCode  (waitCode),
  .burstMode (burstMode),
  .readArray (readArray),
  .cfgDone   (cfgDone)
);

// File: tb/test_flash_cfg_decoder.sv
`timescale 1ns/1ps
module test_flash_cfg_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValidN = 1'b1;
  logic        writeEnN = 1'b1;
  logic [19:0] addrIn = '0;
  logic [15:0] dataIn = '0;
  logic [2:0]  waitCode;
  logic [3:0]  accessClocks;
  logic [1:0]  burstMode;
  logic        readArray;
  logic        cfgDone;

  int errors = 0;
  int checks = 0;

  // Reference model state
  int          mState = 0;
  logic [2:0]  mWait = 3'd5;
  logic [1:0]  mBurst = 2'b00;
  logic        mDone = 1'b0;
  logic [19:0] mLatch = '0;

  always #2 clk = ~clk;

  flash_cfg_decoder i_flash_cfg_decoder (
    .clk          (clk),
    .rstN         (rstN),
    .addrValidN   (addrValidN),
    .writeEnN     (writeEnN),
    .addrIn       (addrIn),
    .dataIn       (dataIn),
    .waitCode     (waitCode),
    .accessClocks (accessClocks),
    .burstMode    (burstMode),
    .readArray    (readArray),
    .cfgDone      (cfgDone)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, "readArray", int'(readArray), (mState == 0) ? 1 : 0);
    check(req, "waitCode", int'(waitCode), int'(mWait));
    check(req, "accessClocks", int'(accessClocks), int'(mWait) + 2);
    check(req, "burstMode", int'(burstMode), int'(mBurst));
    check(req, "cfgDone", int'(cfgDone), int'(mDone));
  endtask

  // Expected behaviour derived from the requirements
  task automatic modelWrite(logic [15:0] d);
    logic [11:0] lowA;
    logic [7:0]  lowD;
    lowA = mLatch[11:0];
    lowD = d[7:0];
    mDone = 1'b0;
    case (mState)
      0: mState = (lowA == 12'h555 && lowD == 8'hAA) ? 1 : 0;
      1: mState = (lowA == 12'h2AA && lowD == 8'h55) ? 2 : 0;
      default: begin
        if (lowA == 12'h555 && lowD == 8'hC0 && mLatch[14:12] <= 3'd5) begin
          mWait  = mLatch[14:12];
          mBurst = mLatch[16:15];
          mDone  = 1'b1;
        end
        mState = 0;
      end
    endcase
  endtask

  task automatic avdPulse(logic [19:0] a);
    @(negedge clk);
    addrIn = a;
    addrValidN = 1'b0;
    @(negedge clk);
    addrValidN = 1'b1;
    mLatch = a;
    @(negedge clk);
  endtask

  task automatic wePulse(logic [15:0] d, string req);
    @(negedge clk);
    dataIn = d;
    writeEnN = 1'b0;
    @(negedge clk);
    writeEnN = 1'b1;
    modelWrite(d);
    @(negedge clk);
    checkAll(req);
    mDone = 1'b0;
    @(negedge clk);
    check(req, "cfgDone after pulse", int'(cfgDone), 0);
  endtask

  task automatic busWrite(logic [19:0] a, logic [15:0] d, string req);
    avdPulse(a);
    wePulse(d, req);
  endtask

  // Write with a new address on the bus but no address strobe
  task automatic writeNoAvd(logic [19:0] a, logic [15:0] d, string req);
    @(negedge clk);
    addrIn = a;
    wePulse(d, req);
  endtask

  function automatic logic [19:0] cfgAddr(logic [2:0] hi, logic [1:0] burst, logic [2:0] code);
    return {hi, burst, code, 12'h555};
  endfunction

  task automatic fullSeq(logic [1:0] burst, logic [2:0] code, string req);
    busWrite(20'h00555, 16'h00AA, req);
    busWrite(20'h002AA, 16'h0055, req);
    busWrite(cfgAddr(3'b000, burst, code), 16'h00C0, req);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    repeat (3) @(negedge clk);
    // R1 reset state
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R3 R4 R5 directed loads
    fullSeq(2'b01, 3'd2, "R3");
    fullSeq(2'b11, 3'd0, "R4");
    fullSeq(2'b10, 3'd5, "R5");
    fullSeq(2'b00, 3'd3, "R4");

    // R6 illegal codes
    fullSeq(2'b11, 3'd6, "R6");
    fullSeq(2'b01, 3'd7, "R6");

    // R7 wrong order: repeated first unlock aborts, tail then ignored
    busWrite(20'h00555, 16'h00AA, "R7");
    busWrite(20'h00555, 16'h00AA, "R7");
    busWrite(20'h002AA, 16'h0055, "R7");
    busWrite(cfgAddr(3'b000, 2'b10, 3'd1), 16'h00C0, "R7");
    // R7 wrong data on third cycle
    busWrite(20'h00555, 16'h00AA, "R7");
    busWrite(20'h002AA, 16'h0055, "R7");
    busWrite(cfgAddr(3'b000, 2'b10, 3'd1), 16'h00C1, "R7");
    // R8 command write out of order
    busWrite(cfgAddr(3'b000, 2'b10, 3'd1), 16'h00C0, "R8");

    // R2 address bus change without a strobe keeps latched address
    busWrite(20'h00555, 16'h00AA, "R2");
    writeNoAvd(20'h002AA, 16'h0055, "R2");

    // R10 ignored upper bits
    busWrite(20'hE0555, 16'hFFAA, "R10");
    busWrite(20'hA02AA, 16'h3C55, "R10");
    busWrite(cfgAddr(3'b111, 2'b10, 3'd4), 16'h5AC0, "R10");

    // Random mix
    for (int it = 0; it < 150; it++) begin
      int kind;
      kind = $urandom_range(0, 2);
      if (kind == 0) begin
        logic [2:0] hi;
        logic [1:0] bm;
        logic [2:0] cd;
        hi = 3'($urandom);
        bm = 2'($urandom);
        cd = 3'($urandom);
        busWrite({hi, 5'($urandom), 12'h555}, {8'($urandom), 8'hAA}, "R3");
        busWrite({hi, 5'($urandom), 12'h2AA}, {8'($urandom), 8'h55}, "R3");
        busWrite(cfgAddr(hi, bm, cd), {8'($urandom), 8'hC0}, "R6");
      end else if (kind == 1) begin
        int bad;
        bad = $urandom_range(0, 2);
        for (int s = 0; s < 3; s++) begin
          logic [11:0] a;
          logic [7:0]  d;
          a = (s == 1) ? 12'h2AA : 12'h555;
          d = (s == 0) ? 8'hAA : ((s == 1) ? 8'h55 : 8'hC0);
          if (s == bad) begin
            if ($urandom_range(0, 1) == 0) a = a ^ 12'(1 << $urandom_range(0, 11));
            else d = d ^ 8'(1 << $urandom_range(0, 7));
          end
          busWrite({3'($urandom), 2'($urandom), 3'($urandom_range(0, 5)), a}, {8'($urandom), d}, "R7");
        end
      end else begin
        busWrite(20'($urandom), 16'($urandom), "R8");
      end
    end

    // Hardware reset restores defaults (R1)
    fullSeq(2'b11, 3'd1, "R3");
    @(negedge clk);
    rstN = 1'b0;
    mState = 0; mWait = 3'd5; mBurst = 2'b00; mDone = 1'b0; mLatch = '0;
    @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    finishRun();
  end

endmodule